// File: doc/BRIEF.md
# Receive Gain and Slicer Control Loop

This block is the digital side of a line receiver's front end. It receives one signed ADC sample per symbol period, along with a strobe that marks each symbol. It measures the largest sample magnitude over a programmable observation window. At each window boundary it moves a 6-bit gain code for an external variable-gain amplifier by at most one step. The goal is to keep the peak level between three quarters of full scale and full scale.

The same window peak sets the slicer's decision threshold for the next window. That threshold is half of the peak. The block emits one recovered bit per symbol. An optional squelch forces the recovered bits to zero after a window in which no sample reached the threshold.

A fixed-gain mode holds the code at a programmed ceiling and stops adaptation. A pad-compensation setting raises the ceiling in steps of 8 gain codes, to make up for a resistive attenuator in front of the receiver.

Top module: `rx_agc_ctrl`

## Requirements
- R1: During and right after a synchronous active-low reset, `gain_code` equals the ceiling defined in R6, `eye_open` is 1, `slice_valid` is 0 and the stored threshold is 0.
- R2: The window length is set by `cfg_win`: 0 gives 32 symbols, 1 gives 128, 2 gives 512 and 3 gives 2048. Only cycles with `sym_valid` high count toward the window. In gain-limit mode `gain_code` changes only on the clock edge that takes the last symbol of a window.
- R3: The magnitude of a sample is its absolute value, with -128 read as 127. When the window peak is 127 (full scale), the gain code drops by one at the window end, but never below 0.
- R4: When the window peak is below 95 (three quarters of full scale), the gain code rises by one at the window end, but never above the ceiling.
- R5: When the window peak lies from 95 to 126, the gain code holds.
- R6: The ceiling is min(63, `cfg_gain_max` + 8 × `cfg_pad`). In gain-limit mode the gain code is pulled down to the ceiling within one cycle whenever it is above it.
- R7: With `cfg_fixed` = 1 the gain code equals the ceiling one cycle later and ignores the sample peaks. On leaving fixed mode the code starts from the ceiling, which is the maximum sensitivity.
- R8: The threshold is the previous window's peak shifted right by one. A symbol is a mark (1) when its magnitude is greater than or equal to the threshold. `slice_valid` and `slice_bit` appear one cycle after the symbol.
- R10: At each window end `eye_open` is set to 1 if any symbol of that window reached the threshold in force, and to 0 otherwise.
- R11: With `cfg_squelch` = 1 and `eye_open` = 0, every `slice_bit` is 0.
- R12: The peak register clears at each window boundary, so a window's peak reflects only its own symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fixed | input | 1 | 1 selects fixed gain, 0 selects gain-limit adaptation |
| cfg_win | input | 2 | Window length select (32/128/512/2048 symbols) |
| cfg_gain_max | input | 6 | Programmed maximum gain code |
| cfg_pad | input | 2 | Pad compensation, adds 8 codes per step |
| cfg_squelch | input | 1 | Enables forcing of zeros while the eye is closed |
| sym_valid | input | 1 | Marks a cycle carrying one symbol sample |
| sample | input | ADC_W | Signed two's-complement ADC sample |
| gain_code | output | 6 | Gain code to the amplifier; also status |
| eye_open | output | 1 | 1 when the last window had a threshold crossing |
| slice_valid | output | 1 | Qualifies slice_bit |
| slice_bit | output | 1 | Recovered symbol decision |

## Verification
The recovered bit for a symbol is due one clock after that symbol is presented. The bench pushes each expected bit into a queue when it drives the symbol, and a monitor pops it on the following falling edge, when `slice_valid` is high. `gain_code` and `eye_open` change on the edge that takes a window's last symbol. They are therefore sampled on the falling edge after it, with an extra check one symbol earlier to confirm that nothing moved before the boundary. A configuration change shows on `gain_code` after one edge, and it is checked on the next falling edge.

// File: rtl/rx_agc_pkg.sv
// Shared types and helpers for the receive gain loop.
// Assumes a 6-bit gain code and a pad step of 8 codes.
package rx_agc_pkg;
    localparam int GAIN_W   = 6;
    localparam int PAD_STEP = 8;

    typedef logic [GAIN_W-1:0] gain_t;

    // Ceiling: programmed maximum plus pad offset, saturated to the code range.
    function automatic gain_t ceil_calc(input gain_t gmax, input logic [1:0] pad);
        logic [GAIN_W:0] sum;
        sum = {1'b0, gmax} + (GAIN_W+1)'(PAD_STEP * int'(pad));
        if (sum > (GAIN_W+1)'((1 << GAIN_W) - 1))
            return '1;
        return sum[GAIN_W-1:0];
    endfunction
endpackage

// File: rtl/rx_agc_window.sv
// Observation window timer and peak tracker.
// It counts valid symbols up to a length of 2^(BASE_LOG2 + 2*win_sel).
// It keeps the running peak magnitude, flags the last symbol of each window,
// and latches the finished window's peak for the slicer.
// Assumes win_sel is changed only at window boundaries; a shorter window
// chosen mid-window ends at the next symbol.
module rx_agc_window #(
    parameter int MAG_W     = 7,
    parameter int BASE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [MAG_W-1:0] mag,
    input  logic [1:0]       win_sel,
    output logic             win_end,
    output logic [MAG_W-1:0] win_peak,
    output logic [MAG_W-1:0] last_peak
);
    localparam int CNT_W = BASE_LOG2 + 6;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_last;
    logic [2:0]       shamt;
    logic [MAG_W-1:0] peak;

    // Terminal count: all-ones shifted down for the shorter windows.
    always_comb begin
        shamt    = 3'd6 - {win_sel, 1'b0};
        cnt_last = {CNT_W{1'b1}} >> shamt;
        win_end  = sym_valid && (cnt >= cnt_last);
        win_peak = (mag > peak) ? mag : peak;
    end

    // Advance the counter and peak; restart both at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            peak      <= '0;
            last_peak <= '0;
        end else if (sym_valid) begin
            if (win_end) begin
                cnt       <= '0;
                peak      <= '0;
                last_peak <= win_peak;
            end else begin
                cnt  <= cnt + 1'b1;
                peak <= win_peak;
            end
        end
    end
endmodule

// File: rtl/rx_agc_gain.sv
// Gain code stepper.
// Fixed mode: the code follows the ceiling.
// Limit mode: the code is clamped to the ceiling every cycle and stepped by
// one at window ends, from where the window peak sits against the target band.
// Assumes win_peak includes the symbol that closes the window.
module rx_agc_gain
    import rx_agc_pkg::*;
#(
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fixed_mode,
    input  gain_t            ceil,
    input  logic             win_end,
    input  logic [MAG_W-1:0] win_peak,
    output gain_t            gain
);
    localparam int FULL_I = (1 << MAG_W) - 1;
    localparam int LOW_I  = (3 * FULL_I) / 4;
    localparam logic [MAG_W-1:0] FULL_LVL = MAG_W'(FULL_I);
    localparam logic [MAG_W-1:0] LOW_LVL  = MAG_W'(LOW_I);

    gain_t clamped;
    gain_t gain_nxt;

    // Next code: follow the ceiling, or clamp then step at window end.
    always_comb begin
        clamped  = (gain > ceil) ? ceil : gain;
        gain_nxt = clamped;
        if (fixed_mode) begin
            gain_nxt = ceil;
        end else if (win_end) begin
            if (win_peak >= FULL_LVL) begin
                if (clamped != '0) gain_nxt = clamped - 1'b1;
            end else if (win_peak < LOW_LVL) begin
                if (clamped < ceil) gain_nxt = clamped + 1'b1;
            end
        end
    end

    // Register the code; reset starts at maximum sensitivity.
    always_ff @(posedge clk) begin
        if (!rst_n) gain <= ceil;
        else        gain <= gain_nxt;
    end
endmodule

// File: rtl/rx_agc_slicer.sv
// Data slicer and eye detector.
// Decides each symbol against half the previous window's peak, tracks whether
// any symbol in the window reached that threshold, and gates the output with
// squelch while the eye is closed.
// Assumes last_peak is stable within a window.
module rx_agc_slicer #(
    parameter int MAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [MAG_W-1:0] mag,
    input  logic [MAG_W-1:0] last_peak,
    input  logic             win_end,
    input  logic             squelch_en,
    output logic             eye_open,
    output logic             slice_valid,
    output logic             slice_bit
);
    logic [MAG_W-1:0] thresh;
    logic             hit;
    logic             crossed;

    // Threshold at half the previous peak; a mark meets or exceeds it.
    always_comb begin
        thresh = last_peak >> 1;
        hit    = (mag >= thresh);
    end

    // Remember a crossing within the window; publish it at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crossed  <= 1'b0;
            eye_open <= 1'b1;
        end else if (sym_valid) begin
            if (win_end) begin
                crossed  <= 1'b0;
                eye_open <= crossed | hit;
            end else begin
                crossed  <= crossed | hit;
            end
        end
    end

    // Register one decision per symbol, forced low under squelch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_valid <= 1'b0;
            slice_bit   <= 1'b0;
        end else begin
            slice_valid <= sym_valid;
            slice_bit   <= sym_valid && hit && (eye_open || !squelch_en);
        end
    end
endmodule

// File: rtl/rx_agc_ctrl.sv
// Top of the receive gain and slicer control loop.
// Converts the signed sample to a saturated magnitude, forms the gain ceiling,
// and ties together the window tracker, gain stepper and slicer.
// Assumes one sample per sym_valid pulse and ADC_W >= 3.
module rx_agc_ctrl
    import rx_agc_pkg::*;
#(
    parameter int ADC_W         = 8,
    parameter int WIN_BASE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_fixed,
    input  logic [1:0]       cfg_win,
    input  logic [5:0]       cfg_gain_max,
    input  logic [1:0]       cfg_pad,
    input  logic             cfg_squelch,
    input  logic             sym_valid,
    input  logic [ADC_W-1:0] sample,
    output logic [5:0]       gain_code,
    output logic             eye_open,
    output logic             slice_valid,
    output logic             slice_bit
);
    localparam int MAG_W = ADC_W - 1;

    logic [ADC_W-1:0] abs_val;
    logic [MAG_W-1:0] mag;
    logic             win_end;
    logic [MAG_W-1:0] win_peak;
    logic [MAG_W-1:0] last_peak;
    gain_t            gain_ceil;

    // Absolute value; the most negative code saturates to full scale.
    always_comb begin
        abs_val   = sample[ADC_W-1] ? (~sample + 1'b1) : sample;
        mag       = abs_val[ADC_W-1] ? {MAG_W{1'b1}} : abs_val[MAG_W-1:0];
        gain_ceil = ceil_calc(cfg_gain_max, cfg_pad);
    end

    rx_agc_window #(.MAG_W(MAG_W), .BASE_LOG2(WIN_BASE_LOG2)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .mag       (mag),
        .win_sel   (cfg_win),
        .win_end   (win_end),
        .win_peak  (win_peak),
        .last_peak (last_peak)
    );

    rx_agc_gain #(.MAG_W(MAG_W)) u_gain (
        .clk        (clk),
        .rst_n      (rst_n),
        .fixed_mode (cfg_fixed),
        .ceil       (gain_ceil),
        .win_end    (win_end),
        .win_peak   (win_peak),
        .gain       (gain_code)
    );

    rx_agc_slicer #(.MAG_W(MAG_W)) u_slicer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid   (sym_valid),
        .mag         (mag),
        .last_peak   (last_peak),
        .win_end     (win_end),
        .squelch_en  (cfg_squelch),
        .eye_open    (eye_open),
        .slice_valid (slice_valid),
        .slice_bit   (slice_bit)
    );
endmodule

// File: rtl/rx_agc_ctrl_chk.sv
// Property checker for rx_agc_ctrl, attached with bind.
// Observes ports plus the window-end strobe and the computed ceiling.
module rx_agc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_fixed,
    input logic       cfg_squelch,
    input logic       sym_valid,
    input logic       win_end,
    input logic [5:0] ceil,
    input logic [5:0] gain_code,
    input logic       eye_open,
    input logic       slice_valid,
    input logic       slice_bit
);
    // Between window ends the adapted code does not move.
    assert_gain_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fixed && !win_end && gain_code <= ceil) |=> $stable(gain_code));

    // A window end moves the code by at most one step (R3, R4).
    assert_gain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fixed && win_end && gain_code <= ceil) |=>
        (({1'b0, gain_code} <= {1'b0, $past(gain_code)} + 7'd1) &&
         ({1'b0, $past(gain_code)} <= {1'b0, gain_code} + 7'd1)));

    // Adapted code never sits above the ceiling after an edge.
    assert_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fixed |=> (gain_code <= $past(ceil)));

    // Fixed mode tracks the ceiling.
    assert_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fixed |=> (gain_code == $past(ceil)));

    // One decision per symbol, one cycle later.
    assert_slice_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> slice_valid);

    assert_slice_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> (!slice_valid && !slice_bit));

    // Squelch with a closed eye yields only zeros.
    assert_squelch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && cfg_squelch && !eye_open) |=> !slice_bit);
endmodule

bind rx_agc_ctrl rx_agc_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fixed   (cfg_fixed),
    .cfg_squelch (cfg_squelch),
    .sym_valid   (sym_valid),
    .win_end     (win_end),
    .ceil        (gain_ceil),
    .gain_code   (gain_code),
    .eye_open    (eye_open),
    .slice_valid (slice_valid),
    .slice_bit   (slice_bit)
);

// File: tb/rx_agc_ctrl_tb.sv
// Scoreboard bench for rx_agc_ctrl: a driver queues expected slice bits from a
// requirement-level model, and a monitor compares them as they emerge.
module rx_agc_ctrl_tb;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_fixed = 1'b0;
    logic [1:0]       cfg_win = 2'd0;
    logic [5:0]       cfg_gain_max = 6'd40;
    logic [1:0]       cfg_pad = 2'd0;
    logic             cfg_squelch = 1'b0;
    logic             sym_valid = 1'b0;
    logic [7:0]       sample = 8'd0;
    logic [5:0]       gain_code;
    logic             eye_open;
    logic             slice_valid;
    logic             slice_bit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    int m_gain, m_last, m_peak, m_cnt, m_eye, m_cross;

    always #2 clk = ~clk;

    rx_agc_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_fixed    (cfg_fixed),
        .cfg_win      (cfg_win),
        .cfg_gain_max (cfg_gain_max),
        .cfg_pad      (cfg_pad),
        .cfg_squelch  (cfg_squelch),
        .sym_valid    (sym_valid),
        .sample       (sample),
        .gain_code    (gain_code),
        .eye_open     (eye_open),
        .slice_valid  (slice_valid),
        .slice_bit    (slice_bit)
    );

    function automatic int ceil_f();
        int v;
        v = int'(cfg_gain_max) + 8 * int'(cfg_pad);
        return (v > 63) ? 63 : v;
    endfunction

    function automatic int win_len();
        return 32 << (2 * int'(cfg_win));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: present one symbol and queue its expected decision.
    task automatic drive_sym(input int s);
        int mag;
        int ceil;
        bit hit;
        @(negedge clk);
        sample    = 8'(s);
        sym_valid = 1'b1;
        mag  = (s < 0) ? -s : s;
        if (mag > 127) mag = 127;
        hit  = (mag >= m_last / 2);
        exp_q.push_back(hit && (m_eye != 0 || !cfg_squelch));
        tag_q.push_back(cfg_squelch ? "R11" : "R8");
        if (mag > m_peak) m_peak = mag;
        if (hit) m_cross = 1;
        m_cnt++;
        if (m_cnt == win_len()) begin
            ceil   = ceil_f();
            m_last = m_peak;
            if (cfg_fixed) m_gain = ceil;
            else begin
                if (m_gain > ceil) m_gain = ceil;
                if (m_peak >= 127) begin
                    if (m_gain > 0) m_gain--;
                end else if (m_peak < 95) begin
                    if (m_gain < ceil) m_gain++;
                end
            end
            m_eye   = m_cross;
            m_cross = 0;
            m_peak  = 0;
            m_cnt   = 0;
        end
    endtask

    task automatic check_status(input string req_g, input string req_e);
        @(negedge clk);
        sym_valid = 1'b0;
        check(req_g, int'(gain_code), m_gain);
        check(req_e, int'(eye_open), m_eye);
    endtask

    // One full window: alternating +/-lo with a single hi in the middle.
    // The gain is also checked one symbol before the boundary (R2).
    task automatic run_window(input int hi, input int lo, input string req);
        int n;
        n = win_len();
        for (int i = 0; i < n - 1; i++)
            drive_sym((i == n / 2) ? hi : ((i % 2 != 0) ? lo : -lo));
        check_status("R2", "R10");
        drive_sym((n / 2 == n - 1) ? hi : lo);
        check_status(req, "R10");
    endtask

    task automatic set_cfg(input bit fixed, input int gmax, input int pad, input string req);
        int ceil;
        @(negedge clk);
        sym_valid    = 1'b0;
        cfg_fixed    = fixed;
        cfg_gain_max = 6'(gmax);
        cfg_pad      = 2'(pad);
        ceil = ceil_f();
        if (fixed || m_gain > ceil) m_gain = ceil;
        @(negedge clk);
        check(req, int'(gain_code), m_gain);
    endtask

    // Monitor: compare each emerging decision with the queue head.
    always @(negedge clk) begin
        if (rst_n && slice_valid) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R8: actual unexpected slice_valid expected none");
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(slice_bit), int'(e));
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_gain = ceil_f(); m_last = 0; m_peak = 0; m_cnt = 0; m_eye = 1; m_cross = 0;
        @(negedge clk);
        // R1: reset state
        check("R1", int'(gain_code), 40);
        check("R1", int'(eye_open), 1);
        check("R1", int'(slice_valid), 0);

        run_window(127, 20, "R3");       // full-scale peak: 40 -> 39
        run_window(100, 40, "R5");       // in band: hold, threshold 50
        // R8: explicit decisions around threshold 50
        drive_sym(50); drive_sym(49); drive_sym(-60); drive_sym(-49);
        for (int i = 4; i < 32; i++) drive_sym((i == 10) ? 100 : 20);
        check_status("R5", "R10");
        run_window(-128, 10, "R3");      // -128 counts as full scale: 38
        run_window(120, 30, "R5");       // hold, threshold 60
        run_window(30, 10, "R12");       // peak cleared: rises to 39, eye closes
        check("R10", int'(eye_open), 0);
        cfg_squelch = 1'b1;
        run_window(20, 20, "R11");       // hits forced to 0; eye reopens
        run_window(20, 5, "R4");         // squelch with open eye: marks pass
        cfg_squelch = 1'b0;

        for (int w = 1; w < 4; w++) begin // R2: longer windows
            @(negedge clk);
            sym_valid = 1'b0;
            cfg_win   = 2'(w);
            run_window(127, 20, "R2");
        end
        @(negedge clk);
        cfg_win = 2'd0;

        set_cfg(1'b0, 40, 2, "R6");      // ceiling 56
        run_window(50, 10, "R4");
        run_window(50, 10, "R4");
        set_cfg(1'b1, 30, 1, "R7");      // fixed: 38
        run_window(127, 5, "R7");
        set_cfg(1'b0, 10, 0, "R6");      // clamp to 10
        run_window(50, 5, "R4");
        set_cfg(1'b1, 60, 3, "R6");      // saturates at 63
        check("R6", int'(gain_code), 63);
        set_cfg(1'b1, 0, 0, "R7");
        set_cfg(1'b0, 0, 0, "R6");
        run_window(127, 5, "R3");        // floor at 0
        check("R3", int'(gain_code), 0);

        repeat (3) @(negedge clk);
        check("R8", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule